// File: doc/BRIEF.md
# Frequency Synthesizer Loop Digital Core

This block holds the digital half of a frequency-synthesizer phase-locked loop. A 75 kHz crystal strobe is divided down to one of six reference rates. The selected VCO pulse stream (already prescaled and synchronised to the system clock) is divided by a programmable 16-bit ratio. The two divided edge streams are compared in a phase-frequency detector. The detector's result leaves the block as a three-state pump code: drive high, drive low, or release.

A short dead-band filter stops narrow correction pulses from reaching the pump. A sticky unlock flag records cycle slips until software tests it. Halt, an unused reference code and reset all release the pump. The analog pump, the loop filter and the input amplifiers sit outside the block. They take `pump_hi`, `pump_lo` (both low means high impedance) and `am_lf_sel`.

Configuration goes through a small write port. The address picks one of four fields:
- address 0: the divide ratio N.
- address 1: the reference code, in bits [2:0].
- address 2: the band code, in bits [1:0].
- address 3: the dead-band mode, in bit 0.

Top module: `pll_core`

## Requirements
- R1: After reset both pump outputs are low (released), the unlock flag is 0, the reference code is 7 (stopped), the band code is 00 and `am_lf_sel` is 0.
- R2: Reference codes 0,1,2,3,4,5 divide the crystal strobe by 75,25,15,12,6,3. The first reference edge comes on the first crystal strobe after the loop starts running. Later edges come every ratio strobes.
- R3: Reference codes 6 and 7 stop the loop. From the first cycle after such a code is written, both pump outputs are low, all pending drive is cleared, and both dividers are held at their start values.
- R4: Band codes 00 and 01 feed `fm_tick` to the N divider, and codes 10 and 11 feed `am_tick`. The input not selected has no effect. `am_lf_sel` is 1 only for code 11.
- R5: The N divider gives one divided edge every N selected VCO pulses, with N=0 treated as 1. A newly written N is first used at the next terminal count, so the period already running completes with the old N.
- R6: A divided edge with no reference edge pending sets high drive. A reference edge with no divided edge pending sets low drive. The opposite edge releases the drive. The two outputs are never high together.
- R7: A divided edge and a reference edge in the same cycle produce no drive.
- R8: In dead-band mode 0 a pending drive shows on its output from its second cycle onward. In mode 1 it shows from its fourth cycle onward. Shorter drives never appear.
- R9: The unlock flag is set when a reference edge arrives while low drive is still pending, or a divided edge arrives while high drive is still pending. It stays set until read.
- R10: A one-cycle pulse on `unlk_rd` clears the flag at the next clock edge, unless a new slip occurs in that same cycle.
- R11: While `halt` is high both pump outputs are low in the same cycle. Pending drive is cleared at the next edge. The reference counter restarts as in R2 when `halt` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Field select: 0 N, 1 reference code, 2 band code, 3 dead-band mode |
| cfg_wdata | input | 16 | Write data (N_W bits) |
| xtal_tick | input | 1 | One-cycle strobe at the crystal rate |
| fm_tick | input | 1 | One-cycle pulse per prescaled FM VCO period |
| am_tick | input | 1 | One-cycle pulse per prescaled AM VCO period |
| halt | input | 1 | Halt mode: forces pump release |
| unlk_rd | input | 1 | Test-and-clear strobe for the unlock flag |
| pump_hi | output | 1 | Drive pump output high |
| pump_lo | output | 1 | Drive pump output low |
| unlock_flag | output | 1 | Sticky unlock indication |
| am_lf_sel | output | 1 | Selects the low AM range for the input amplifier |

## Verification
The bench builds the block with its defaults: a 16-bit N and dead-band widths of 2 and 4 cycles. The crystal strobe is held high on every clock, so even the slowest reference (divide by 75) and every slip condition fit in a few dozen cycles. Ratios of 1 to 4 together with the fast reference codes are enough to create leading, lagging, coincident and slipping edge patterns. Writing N in mid-period shows whether the period already running is kept.

// File: rtl/pll_pkg.sv
package pll_pkg;

    localparam int SEL_W  = 3;
    localparam int BAND_W = 2;
    localparam int RCNT_W = 7;

    localparam logic [1:0] ADDR_NDIV  = 2'd0;
    localparam logic [1:0] ADDR_REF   = 2'd1;
    localparam logic [1:0] ADDR_BAND  = 2'd2;
    localparam logic [1:0] ADDR_DBAND = 2'd3;

    localparam logic [SEL_W-1:0] SEL_STOP = 3'd7;

    // reload value (ratio - 1) of the reference counter; stop codes give 0
    function automatic logic [RCNT_W-1:0] ref_reload(input logic [SEL_W-1:0] sel);
        case (sel)
            3'd0:    return 7'd74;
            3'd1:    return 7'd24;
            3'd2:    return 7'd14;
            3'd3:    return 7'd11;
            3'd4:    return 7'd5;
            3'd5:    return 7'd2;
            default: return 7'd0;
        endcase
    endfunction

    function automatic logic sel_runs(input logic [SEL_W-1:0] sel);
        return sel < 3'd6;
    endfunction

endpackage

// File: rtl/pll_ref_div.sv
module pll_ref_div #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             xtal_tick,
    input  logic [CNT_W-1:0] reload,
    output logic             ref_edge
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ref_st_t;

    ref_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        ref_edge = run && xtal_tick && (st_q.cnt == '0);
        if (!run) begin
            st_d.cnt = '0;
        end else if (xtal_tick) begin
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pll_n_div.sv
module pll_n_div #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             vco_tick,
    input  logic [CNT_W-1:0] n_val,
    output logic             div_edge
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } ndiv_st_t;

    ndiv_st_t         st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        st_d     = st_q;
        reload   = (n_val == '0) ? '0 : n_val - 1'b1;
        div_edge = run && vco_tick && (st_q.cnt == '0);
        if (!run) begin
            st_d.cnt = reload;
        end else if (vco_tick) begin
            st_d.cnt = (st_q.cnt == '0) ? reload : st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd #(
    parameter int DB_NARROW = 2,
    parameter int DB_WIDE   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_edge,
    input  logic div_edge,
    input  logic db_wide,
    input  logic unlk_rd,
    output logic pump_hi,
    output logic pump_lo,
    output logic unlock_flag,
    output logic pend_hi,
    output logic pend_lo
);

    localparam int WC_W = $clog2(DB_WIDE) + 1;
    localparam logic [WC_W-1:0] WC_MAX    = {WC_W{1'b1}};
    localparam logic [WC_W-1:0] TH_NARROW = WC_W'(DB_NARROW - 1);
    localparam logic [WC_W-1:0] TH_WIDE   = WC_W'(DB_WIDE - 1);

    typedef struct packed {
        logic            hi;
        logic            lo;
        logic            flag;
        logic [WC_W-1:0] wc;
    } pfd_st_t;

    pfd_st_t         st_d, st_q;
    logic            next_hi, next_lo, slip;
    logic [WC_W-1:0] thresh;

    always_comb begin
        st_d    = st_q;
        next_hi = st_q.hi | div_edge;
        next_lo = st_q.lo | ref_edge;
        slip    = (st_q.lo && ref_edge && !div_edge) ||
                  (st_q.hi && div_edge && !ref_edge);

        if (!run || (next_hi && next_lo)) begin
            st_d.hi = 1'b0;
            st_d.lo = 1'b0;
        end else begin
            st_d.hi = next_hi;
            st_d.lo = next_lo;
        end

        if ((st_q.hi || st_q.lo) && (st_d.hi || st_d.lo))
            st_d.wc = (st_q.wc == WC_MAX) ? st_q.wc : st_q.wc + 1'b1;
        else
            st_d.wc = '0;

        if (slip)         st_d.flag = 1'b1;
        else if (unlk_rd) st_d.flag = 1'b0;

        thresh      = db_wide ? TH_WIDE : TH_NARROW;
        pump_hi     = run && st_q.hi && (st_q.wc >= thresh);
        pump_lo     = run && st_q.lo && (st_q.wc >= thresh);
        unlock_flag = st_q.flag;
        pend_hi     = st_q.hi;
        pend_lo     = st_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pll_core.sv
module pll_core
    import pll_pkg::*;
#(
    parameter int N_W       = 16,
    parameter int DB_NARROW = 2,
    parameter int DB_WIDE   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_addr,
    input  logic [N_W-1:0] cfg_wdata,
    input  logic           xtal_tick,
    input  logic           fm_tick,
    input  logic           am_tick,
    input  logic           halt,
    input  logic           unlk_rd,
    output logic           pump_hi,
    output logic           pump_lo,
    output logic           unlock_flag,
    output logic           am_lf_sel
);

    typedef struct packed {
        logic [N_W-1:0]    ndiv;
        logic [SEL_W-1:0]  ref_sel;
        logic [BAND_W-1:0] band;
        logic              db_wide;
    } cfg_t;

    cfg_t              cfg_d, cfg_q;
    logic              run, vco_tick, ref_edge, div_edge;
    logic              pend_hi, pend_lo;
    logic [SEL_W-1:0]  sel_now;
    logic [RCNT_W-1:0] ref_rl;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            case (cfg_addr)
                ADDR_NDIV:  cfg_d.ndiv    = cfg_wdata;
                ADDR_REF:   cfg_d.ref_sel = cfg_wdata[SEL_W-1:0];
                ADDR_BAND:  cfg_d.band    = cfg_wdata[BAND_W-1:0];
                default:    cfg_d.db_wide = cfg_wdata[0];
            endcase
        end
        run       = !halt && sel_runs(cfg_q.ref_sel);
        vco_tick  = cfg_q.band[1] ? am_tick : fm_tick;
        am_lf_sel = (cfg_q.band == 2'b11);
        ref_rl    = ref_reload(cfg_q.ref_sel);
        sel_now   = cfg_q.ref_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q         <= '0;
            cfg_q.ref_sel <= SEL_STOP;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    pll_ref_div #(.CNT_W(RCNT_W)) u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .xtal_tick (xtal_tick),
        .reload    (ref_rl),
        .ref_edge  (ref_edge)
    );

    pll_n_div #(.CNT_W(N_W)) u_ndiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .vco_tick (vco_tick),
        .n_val    (cfg_q.ndiv),
        .div_edge (div_edge)
    );

    pll_pfd #(.DB_NARROW(DB_NARROW), .DB_WIDE(DB_WIDE)) u_pfd (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .ref_edge    (ref_edge),
        .div_edge    (div_edge),
        .db_wide     (cfg_q.db_wide),
        .unlk_rd     (unlk_rd),
        .pump_hi     (pump_hi),
        .pump_lo     (pump_lo),
        .unlock_flag (unlock_flag),
        .pend_hi     (pend_hi),
        .pend_lo     (pend_lo)
    );

endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       halt,
    input logic       unlk_rd,
    input logic       pump_hi,
    input logic       pump_lo,
    input logic       unlock_flag,
    input logic       pend_hi,
    input logic       pend_lo,
    input logic [2:0] sel_now
);

    // R11
    halt_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!pend_hi && !pend_lo));

    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_now >= 3'd6) |=> (!pend_hi && !pend_lo));

    // R6
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pump_hi && pump_lo));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock_flag && !unlk_rd) |=> unlock_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(unlock_flag) |-> $past(unlk_rd));

    // R8
    db_lo_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_lo) |-> $past(pend_lo));

    // R8
    db_hi_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_hi) |-> $past(pend_hi));

endmodule

bind pll_core pll_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt        (halt),
    .unlk_rd     (unlk_rd),
    .pump_hi     (pump_hi),
    .pump_lo     (pump_lo),
    .unlock_flag (unlock_flag),
    .pend_hi     (pend_hi),
    .pend_lo     (pend_lo),
    .sel_now     (sel_now)
);

// File: tb/pll_core_test.sv
`timescale 1ns/1ps
module pll_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        xtal_tick = 1'b0, fm_tick = 1'b0, am_tick = 1'b0;
    logic        halt = 1'b0, unlk_rd = 1'b0;
    logic        pump_hi, pump_lo, unlock_flag, am_lf_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] care;   // [0] hi [1] lo [2] flag [3] am_lf_sel
        logic       hi, lo, flag, amlf;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #10 clk = ~clk;

    pll_core uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .xtal_tick(xtal_tick), .fm_tick(fm_tick),
        .am_tick(am_tick), .halt(halt), .unlk_rd(unlk_rd),
        .pump_hi(pump_hi), .pump_lo(pump_lo), .unlock_flag(unlock_flag),
        .am_lf_sel(am_lf_sel)
    );

    // monitor: compare at the falling edge, away from the active edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            cur = exp_q.pop_front();
            if (cur.care[0]) begin
                checks++;
                if (pump_hi !== cur.hi) begin
                    errors++;
                    $display("FAIL %s pump_hi actual=%0b expected=%0b", cur.tag, pump_hi, cur.hi);
                end
            end
            if (cur.care[1]) begin
                checks++;
                if (pump_lo !== cur.lo) begin
                    errors++;
                    $display("FAIL %s pump_lo actual=%0b expected=%0b", cur.tag, pump_lo, cur.lo);
                end
            end
            if (cur.care[2]) begin
                checks++;
                if (unlock_flag !== cur.flag) begin
                    errors++;
                    $display("FAIL %s unlock_flag actual=%0b expected=%0b", cur.tag, unlock_flag, cur.flag);
                end
            end
            if (cur.care[3]) begin
                checks++;
                if (am_lf_sel !== cur.amlf) begin
                    errors++;
                    $display("FAIL %s am_lf_sel actual=%0b expected=%0b", cur.tag, am_lf_sel, cur.amlf);
                end
            end
        end
    end

    // driver: inputs change just after the rising edge
    task automatic cyc(input logic we, input logic [1:0] a, input logic [15:0] dat,
                       input logic xt, input logic fm, input logic am,
                       input logic hl, input logic rd);
        @(posedge clk);
        #2;
        cfg_we = we; cfg_addr = a; cfg_wdata = dat;
        xtal_tick = xt; fm_tick = fm; am_tick = am; halt = hl; unlk_rd = rd;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] dat);
        cyc(1'b1, a, dat, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic run1(input logic xt, input logic fm, input logic am, input logic hl);
        cyc(1'b0, 2'd0, 16'd0, xt, fm, am, hl, 1'b0);
    endtask

    task automatic expect_out(input logic [3:0] care, input logic h, input logic l,
                              input logic f, input logic m, input string tag);
        exp_t e;
        e.care = care; e.hi = h; e.lo = l; e.flag = f; e.amlf = m; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic stop_clear();
        wr(2'd1, 16'd7);
        cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic measure_ref(input logic [2:0] code, input int ratio);
        stop_clear();
        wr(2'd1, {13'd0, code});
        for (int i = 1; i <= ratio + 1; i++) run1(1'b1, 1'b0, 1'b0, 1'b0);
        expect_out(4'b0100, 0, 0, 0, 0, "R2 no slip before second reference edge");
        run1(1'b1, 1'b0, 1'b0, 1'b0);
        expect_out(4'b0100, 0, 0, 1, 0, "R2 slip at second reference edge");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        run1(1'b1, 1'b1, 1'b1, 1'b0);
        expect_out(4'b1111, 0, 0, 0, 0, "R1 reset state");
        run1(1'b1, 1'b1, 1'b0, 1'b0);
        expect_out(4'b0111, 0, 0, 0, 0, "R1 stopped after reset");

        // R4 band code and range output
        wr(2'd2, 16'd2); run1(0, 0, 0, 0);
        expect_out(4'b1000, 0, 0, 0, 0, "R4 band 10 wide range");
        wr(2'd2, 16'd3); run1(0, 0, 0, 0);
        expect_out(4'b1000, 0, 0, 0, 1, "R4 band 11 low range");
        wr(2'd2, 16'd1); run1(0, 0, 0, 0);
        expect_out(4'b1000, 0, 0, 0, 0, "R4 band 01 FM");

        // R2 all six reference ratios
        wr(2'd3, 16'd0); wr(2'd2, 16'd0);
        measure_ref(3'd0, 75);
        measure_ref(3'd1, 25);
        measure_ref(3'd2, 15);
        measure_ref(3'd3, 12);
        measure_ref(3'd4, 6);
        measure_ref(3'd5, 3);

        // R6 R8 R9 R11 R3 R10: lagging VCO, dead-band mode 0
        stop_clear();
        wr(2'd1, 16'd5);
        run1(1, 0, 0, 0);
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R8 first pending cycle hidden");
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 1, 0, 0, "R6 low drive when VCO lags");
        run1(1, 0, 0, 0);
        run1(1, 0, 0, 0); expect_out(4'b0100, 0, 0, 1, 0, "R9 slip on low side");
        run1(1, 0, 0, 1); expect_out(4'b0011, 0, 0, 0, 0, "R11 halt releases at once");
        run1(1, 0, 0, 1); expect_out(4'b0111, 0, 0, 1, 0, "R9 flag sticky in halt");
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R11 pending cleared");
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R11 restart edge hidden");
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 1, 0, 0, "R11 restart drives low");
        wr(2'd1, 16'd6);
        run1(1, 0, 0, 0); expect_out(4'b0111, 0, 0, 1, 0, "R3 stop code releases");
        run1(1, 0, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R3 stays released");
        cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out(4'b0100, 0, 0, 1, 0, "R10 flag before test edge");
        run1(0, 0, 0, 0); expect_out(4'b0100, 0, 0, 0, 0, "R10 cleared by test");

        // R8 dead-band mode 1
        wr(2'd3, 16'd1);
        stop_clear();
        wr(2'd1, 16'd5);
        for (int i = 1; i <= 4; i++) run1(1, 0, 0, 0);
        expect_out(4'b0011, 0, 0, 0, 0, "R8 mode 1 third cycle hidden");
        run1(1, 0, 0, 0);
        expect_out(4'b0011, 0, 1, 0, 0, "R8 mode 1 fourth cycle shown");

        // R6 R9 leading VCO
        wr(2'd3, 16'd0); wr(2'd0, 16'd1);
        stop_clear();
        wr(2'd1, 16'd4);
        for (int i = 1; i <= 8; i++) begin
            run1(1, 1, 0, 0);
            if (i == 3) expect_out(4'b0111, 0, 0, 0, 0, "R6 high pending hidden");
            if (i == 4) expect_out(4'b0111, 1, 0, 1, 0, "R6 high drive and R9 slip");
            if (i == 7) expect_out(4'b0001, 1, 0, 0, 0, "R6 high held");
            if (i == 8) expect_out(4'b0011, 0, 0, 0, 0, "R6 released by reference");
        end

        // R7 coincident edges
        stop_clear();
        wr(2'd1, 16'd5);
        for (int i = 1; i <= 12; i++) begin
            run1(1, ((i % 3) == 1), 0, 0);
            expect_out(4'b0011, 0, 0, 0, 0, "R7 coincident edges");
        end
        run1(0, 0, 0, 0); expect_out(4'b0100, 0, 0, 0, 0, "R7 no slip when matched");

        // R8 short lag: mode 0 shows one cycle, mode 1 hides it
        wr(2'd0, 16'd3);
        stop_clear();
        wr(2'd1, 16'd5);
        run1(1, 1, 0, 0);
        run1(1, 1, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R8 short pulse hidden at start");
        run1(1, 1, 0, 0); expect_out(4'b0011, 0, 1, 0, 0, "R8 short pulse mode 0 shown");
        run1(1, 1, 0, 0); expect_out(4'b0011, 0, 0, 0, 0, "R8 short pulse ended");
        wr(2'd3, 16'd1);
        stop_clear();
        wr(2'd1, 16'd5);
        for (int i = 1; i <= 12; i++) begin
            run1(1, 1, 0, 0);
            expect_out(4'b0011, 0, 0, 0, 0, "R8 mode 1 suppresses short pulse");
        end
        run1(0, 0, 0, 0); expect_out(4'b0100, 0, 0, 0, 0, "R8 no slip with short lag");

        // R4 AM input selected, FM ignored
        wr(2'd3, 16'd0); wr(2'd0, 16'd1); wr(2'd2, 16'd2);
        stop_clear();
        wr(2'd1, 16'd5);
        for (int i = 1; i <= 12; i++) begin
            run1(1, 1, ((i % 3) == 1), 0);
            expect_out(4'b0011, 0, 0, 0, 0, "R4 FM ignored on AM band");
        end
        run1(0, 0, 0, 0); expect_out(4'b0100, 0, 0, 0, 0, "R4 no slip from ignored input");

        // R5 new N used only at next terminal count
        wr(2'd2, 16'd0); wr(2'd0, 16'd4);
        stop_clear();
        wr(2'd1, 16'd0);
        for (int i = 1; i <= 4; i++) run1(1, 1, 0, 0);
        cyc(1'b1, 2'd0, 16'd2, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        for (int i = 6; i <= 8; i++) run1(1, 1, 0, 0);
        run1(1, 1, 0, 0); expect_out(4'b0101, 0, 0, 0, 0, "R5 old period completed");
        run1(1, 1, 0, 0); expect_out(4'b0101, 1, 0, 0, 0, "R5 high drive shown");
        run1(1, 1, 0, 0); expect_out(4'b0100, 0, 0, 1, 0, "R5 new N after terminal count");

        wr(2'd1, 16'd7);
        repeat (3) run1(0, 0, 0, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule